// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block divides the peripheral clock down to the timing pulses that a serial transmitter and receiver use. A 16-bit divisor holds a fixed-point value. The upper 12 bits are whole clock cycles and the lower 4 bits are sixteenths of a cycle. Each oversample period lasts the whole number of cycles. A 4-bit fraction accumulator stretches some periods by one cycle, so over sixteen periods the average period equals the programmed divisor.

A mode input sets how many oversample ticks make one bit: sixteen when low, eight when high. The resulting bit rate is fclk / (8 × (2 − mode) × divisor). Two single-cycle pulses come out. `sample_tick` marks each oversample period. `bit_tick` marks the last oversample tick of each bit. Dropping the enable, or changing the divisor or the mode, restarts all counting from a clean state.

Top module: `frac_baud_gen`

## Requirements
- R1: `divisor[15:4]` is the integer cycle count I and `divisor[3:0]` is the fraction F in sixteenths.
- R2: Counting from the restart edge (k = 0), the n-th `sample_tick` is high in the cycle after edge k = n·I + floor(n·F/16). No other cycle carries `sample_tick`.
- R3: An integer field of 0 behaves exactly as an integer field of 1.
- R4: With `osr8` = 0, `bit_tick` fires together with every 16th `sample_tick`. With `osr8` = 1, it fires with every 8th. The count starts after the restart.
- R5: `bit_tick` is never high without `sample_tick`. Both outputs are one clock cycle wide whenever I ≥ 2.
- R6: While `en` is low, both outputs stay low. The clock edge at which `en` returns high counts as k = 1.
- R7: A change of `divisor` or `osr8`, as sampled at a clock edge, makes that edge the restart edge k = 0. The outputs are low after that edge.
- R8: While `rst` is high, both outputs are low. The last reset edge acts as the restart edge k = 0.
- R9: Standard rates can be set. With divisor 0x683 at 16× oversampling, a bit lasts 1667 cycles, which is 9598 baud from a 16 MHz clock. The largest divisor 0xFFFF gives periods of 4095 or 4096 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the generator cleared |
| osr8 | input | 1 | 0: 16 ticks per bit, 1: 8 ticks per bit |
| divisor | input | 16 | Fixed-point 12.4 divide value |
| sample_tick | output | 1 | One-cycle oversample pulse |
| bit_tick | output | 1 | One-cycle bit-boundary pulse |

## Verification
Both pulses come from registers. A tick is therefore due in the cycle after the clock edge at which its period completes, and the n-th tick falls after edge n·I + floor(n·F/16) counted from the restart edge. The bench drives inputs at the falling edge. It numbers every rising edge from the restart edge, which is the first edge after a new setting, or the last edge with `en` low or `rst` high. It samples both outputs at the falling edge that follows each rising edge, comparing them with the closed-form tick positions. The sweep covers every fraction, several small integers including the clamped zero and both modes, and adds the rate examples.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int INT_W  = 12;
    localparam int FRAC_W = 4;
    localparam int DIV_W  = INT_W + FRAC_W;

    typedef enum logic {
        OSR_16 = 1'b0,
        OSR_8  = 1'b1
    } osr_e;

    typedef struct packed {
        logic [INT_W-1:0]  whole;
        logic [FRAC_W-1:0] frac;
    } div_fields_t;

    // Split the raw divisor and clamp a zero integer part to one cycle.
    function automatic div_fields_t unpack_div(input logic [DIV_W-1:0] raw);
        div_fields_t f;
        f.whole = raw[DIV_W-1:FRAC_W];
        f.frac  = raw[FRAC_W-1:0];
        if (f.whole == '0) f.whole = INT_W'(1);
        return f;
    endfunction

endpackage

// File: rtl/baud_reload_ctl.sv
module baud_reload_ctl
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             osr8,
    input  logic [DIV_W-1:0] divisor,
    output logic             restart,
    output div_fields_t      fields,
    output osr_e             mode
);

    logic [DIV_W-1:0] div_q;
    logic             osr_q;

    always_ff @(posedge clk) begin
        div_q <= divisor;
        osr_q <= osr8;
    end

    always_comb begin
        restart = !en || (divisor != div_q) || (osr8 != osr_q);
        fields  = unpack_div(divisor);
        mode    = osr_e'(osr8);
    end

endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div #(
    parameter int INT_W  = 12,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [INT_W-1:0]  whole,
    input  logic [FRAC_W-1:0] frac,
    output logic              wrap,
    output logic              tick
);

    localparam int LEN_W = INT_W + 1;

    logic [LEN_W-1:0]  cnt;
    logic [LEN_W-1:0]  cnt_inc;
    logic [LEN_W-1:0]  cur_len;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   acc_sum;
    logic [FRAC_W:0]   look_sum;
    logic [LEN_W-1:0]  base_len;

    always_comb begin
        cnt_inc  = cnt + LEN_W'(1);
        wrap     = (cnt_inc == cur_len);
        acc_sum  = {1'b0, acc} + {1'b0, frac};
        look_sum = {1'b0, acc_sum[FRAC_W-1:0]} + {1'b0, frac};
        base_len = {1'b0, whole};
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt     <= '0;
            acc     <= '0;
            cur_len <= base_len;
            tick    <= 1'b0;
        end else begin
            tick <= wrap;
            if (wrap) begin
                cnt     <= '0;
                acc     <= acc_sum[FRAC_W-1:0];
                cur_len <= base_len + LEN_W'(look_sum[FRAC_W]);
            end else begin
                cnt <= cnt_inc;
            end
        end
    end

endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div
    import baud_pkg::*;
#(
    parameter int OSR_HI = 16,
    parameter int OSR_LO = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  osr_e mode,
    input  logic wrap,
    output logic tick
);

    localparam int CNT_W = $clog2(OSR_HI);

    logic [CNT_W-1:0] scnt;
    logic [CNT_W-1:0] last;

    always_comb begin
        last = (mode == OSR_8) ? CNT_W'(OSR_LO - 1) : CNT_W'(OSR_HI - 1);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            scnt <= '0;
            tick <= 1'b0;
        end else begin
            tick <= wrap && (scnt == last);
            if (wrap) begin
                scnt <= (scnt == last) ? '0 : scnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import baud_pkg::*;
#(
    parameter int OSR_HI = 16,
    parameter int OSR_LO = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             osr8,
    input  logic [DIV_W-1:0] divisor,
    output logic             sample_tick,
    output logic             bit_tick
);

    logic        restart;
    div_fields_t fields;
    osr_e        mode;
    logic        wrap;

    baud_reload_ctl reload_i (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .osr8    (osr8),
        .divisor (divisor),
        .restart (restart),
        .fields  (fields),
        .mode    (mode)
    );

    baud_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) frac_i (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .whole   (fields.whole),
        .frac    (fields.frac),
        .wrap    (wrap),
        .tick    (sample_tick)
    );

    baud_bit_div #(.OSR_HI(OSR_HI), .OSR_LO(OSR_LO)) bit_i (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .mode    (mode),
        .wrap    (wrap),
        .tick    (bit_tick)
    );

endmodule

module frac_baud_gen_chk
    import baud_pkg::*;
#(
    parameter int OSR_HI = 16,
    parameter int OSR_LO = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             osr8,
    input logic [DIV_W-1:0] divisor,
    input logic             sample_tick,
    input logic             bit_tick
);

    logic [DIV_W-1:0] seen_div;
    logic             seen_osr;
    logic [7:0]       ticks_seen;
    logic             fresh;

    assign fresh = !en || (divisor != seen_div) || (osr8 != seen_osr);

    always_ff @(posedge clk) begin
        seen_div <= divisor;
        seen_osr <= osr8;
        if (rst || fresh) begin
            ticks_seen <= '0;
        end else if (sample_tick) begin
            ticks_seen <= bit_tick ? '0 : ticks_seen + 8'd1;
        end
    end

    // R5
    bit_in_sample_chk: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> sample_tick);

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_tick && en && (divisor[DIV_W-1:FRAC_W] > INT_W'(1))) |=> !sample_tick);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!sample_tick && !bit_tick));

    // R7
    reload_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (divisor != $past(divisor)) |=> !sample_tick);

    // R4
    bit_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_tick && !fresh) |-> (ticks_seen == (osr8 ? 8'(OSR_LO - 1) : 8'(OSR_HI - 1))));

endmodule

bind frac_baud_gen frac_baud_gen_chk #(.OSR_HI(OSR_HI), .OSR_LO(OSR_LO)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .osr8        (osr8),
    .divisor     (divisor),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick)
);

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic        osr8;
    logic [15:0] divisor;
    logic        sample_tick;
    logic        bit_tick;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    frac_baud_gen dut_i (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .osr8        (osr8),
        .divisor     (divisor),
        .sample_tick (sample_tick),
        .bit_tick    (bit_tick)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Walk edges k = kstart..kend after a restart edge and compare both pulses
    // against the closed-form positions n*I + floor(n*F/16).
    task automatic observe(input int ie, input int f, input int ratio,
                           input int kstart, input int kend,
                           input string sreq, input string breq);
        int n = 1;
        int s_bad = 0, b_bad = 0;
        int s_k = -1, s_act = 0, s_exp = 0;
        int b_k = -1, b_act = 0, b_exp = 0;
        bit es, eb;
        while (n * ie + (n * f) / 16 < kstart) n++;
        for (int k = kstart; k <= kend; k++) begin
            @(negedge clk);
            es = (k == n * ie + (n * f) / 16);
            eb = es && (n % ratio == 0);
            if (es) n++;
            if (sample_tick !== es) begin
                if (s_bad == 0) begin s_k = k; s_act = int'(sample_tick); s_exp = int'(es); end
                s_bad++;
            end
            if (bit_tick !== eb) begin
                if (b_bad == 0) begin b_k = k; b_act = int'(bit_tick); b_exp = int'(eb); end
                b_bad++;
            end
        end
        check(s_bad == 0, sreq, $sformatf("sample_tick I=%0d F=%0d ratio=%0d edge %0d", ie, f, ratio, s_k), s_act, s_exp);
        check(b_bad == 0, breq, $sformatf("bit_tick I=%0d F=%0d ratio=%0d edge %0d", ie, f, ratio, b_k), b_act, b_exp);
    endtask

    task automatic run_cfg(input int whole, input int f, input bit mode,
                           input int kend, input string sreq, input string breq);
        int ie = (whole == 0) ? 1 : whole;
        @(negedge clk);
        divisor = 16'((whole << 4) | f);
        osr8    = mode;
        en      = 1'b1;
        observe(ie, f, mode ? 8 : 16, 0, kend, sreq, breq);
    endtask

    initial begin
        rst     = 1'b1;
        en      = 1'b0;
        osr8    = 1'b0;
        divisor = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R8: outputs held low during reset
        check(sample_tick == 1'b0 && bit_tick == 1'b0, "R8", "outputs in reset",
              int'(sample_tick) + int'(bit_tick), 0);
        rst = 1'b0;

        // R1 R2 R4: sweep every fraction, small integers, both modes
        for (int m = 0; m < 2; m++) begin
            for (int w = 1; w <= 7; w++) begin
                if (w == 4 || w == 6) continue;
                for (int f = 0; f < 16; f++) begin
                    run_cfg(w, f, m[0], (m[0] ? 10 : 18) * (w + 1) + 2, "R2", "R4");
                end
            end
        end

        // R3: integer field zero clamps to one
        for (int f = 0; f < 16; f++) run_cfg(0, f, 1'b1, 24, "R3", "R3");
        run_cfg(0, 0, 1'b0, 40, "R3", "R3");

        // R9: 9600 baud from 16 MHz, and the largest divisor
        run_cfg(104, 3, 1'b0, 2 * 1667 + 3, "R9", "R9");
        run_cfg(4095, 15, 1'b1, 2 * 4096 + 5, "R9", "R9");

        // R6: disable mid-run, outputs quiet, re-enable counts as edge 1
        run_cfg(3, 5, 1'b1, 20, "R2", "R4");
        @(negedge clk);
        en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(sample_tick == 1'b0 && bit_tick == 1'b0, "R6", "outputs while disabled",
                  int'(sample_tick) + int'(bit_tick), 0);
        end
        en = 1'b1;
        observe(3, 5, 8, 1, 60, "R6", "R6");

        // R7: divisor change mid-period restarts timing
        run_cfg(5, 9, 1'b0, 13, "R2", "R4");
        run_cfg(2, 4, 1'b1, 50, "R7", "R7");
        // R7: mode change alone restarts timing
        @(negedge clk);
        osr8 = 1'b0;
        observe(2, 4, 16, 0, 60, "R7", "R7");

        // R8: reset mid-run, last reset edge is edge 0
        run_cfg(3, 0, 1'b1, 7, "R2", "R4");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(sample_tick == 1'b0 && bit_tick == 1'b0, "R8", "outputs after reset edge",
              int'(sample_tick) + int'(bit_tick), 0);
        rst = 1'b0;
        observe(3, 0, 8, 1, 40, "R8", "R8");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", WATCHDOG, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule